// File: doc/BRIEF.md
# Split Completion Error Responder

This block runs the return path of an inbound read on the target side of a PCI/PCI-X bridge, once the read has been forwarded to an internal bus. It receives beat-by-beat status from the internal bus and termination events from the requester side. From these it issues commands: stream a data beat, send a completion-error message, signal target abort or disconnect-with-data, and release the pending inbound queue entry. A mode input selects between conventional operation and split-transaction operation. A programmable enable chooses how an internal target abort is reported in conventional mode.

A request loads a byte count and a start address. Each 32-bit beat moves the address up by four and the count down by four. In split mode the requester may cut the completion short with a retry or a boundary disconnect. The block then parks the remaining count and address until a resume command arrives. Every terminal outcome raises a one-cycle done pulse that carries a status code. All outputs are registered.

Top module: `scr_resp_top`

## Requirements
- R1: After reset the block is idle, every command output and done pulse is low, and the remaining byte count and current address read zero.
- R2: In split mode an internal-bus target abort during a completion sends a completion message with class 2h and index 81h.
- R3: In split mode an internal-bus master abort sends a completion message with class 2h and index 80h. If both abort kinds arrive in one cycle, the master-abort index 80h is used.
- R4: Every internal-bus abort, in either mode, asserts the queue flush in the same cycle as the abort response, and the block returns to idle.
- R5: In conventional mode an internal-bus master abort is reported as a target abort (done code 2).
- R6: In conventional mode an internal-bus target abort is reported as a target abort (code 2) when the abort-select enable is 1, and as a disconnect with data (code 3) when it is 0.
- R7: In split mode a requester master abort or target abort discards the completion: done with code 4, and no flush, no message, no abort or disconnect signal.
- R8: In split mode a requester retry or boundary disconnect moves the block to a pending state that holds the remaining count and address. A resume pulse continues the completion from there. Neither event produces a done pulse.
- R9: Each delivered beat pushes one data beat, lowers the remaining count by 4 and raises the address by 4. The beat that brings the count to zero ends the transfer with done code 0 and a flush.
- R10: An internal abort that arrives in the same cycle as the final beat takes priority: the abort response is given and no beat is pushed.
- R11: In conventional mode, cycles without a beat never end the transfer, and the retry and boundary-disconnect inputs are ignored.
- R12: Each terminal action raises done for exactly one cycle. The status code is 0 for normal finish, 1 for message sent, 2 for target abort, 3 for disconnect with data, and 4 for discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode_i | input | 1 | 1 = split-transaction mode, 0 = conventional mode |
| ta_sel_i | input | 1 | Conventional-mode choice for internal target abort: 1 = target abort, 0 = disconnect with data |
| req_valid_i | input | 1 | Start a new completion (taken when idle) |
| req_bytes_i | input | BC_W | Byte count of the request, a nonzero multiple of 4 |
| req_addr_i | input | ADDR_W | Start address of the request |
| ib_beat_i | input | 1 | Internal bus delivers one data beat |
| ib_mabort_i | input | 1 | Internal bus master abort |
| ib_tabort_i | input | 1 | Internal bus target abort |
| bus_retry_i | input | 1 | Requester retry termination |
| bus_bdisc_i | input | 1 | Requester disconnect at next allowable boundary |
| bus_mabort_i | input | 1 | Requester ended the completion with master abort |
| bus_tabort_i | input | 1 | Requester ended the completion with target abort |
| resume_i | input | 1 | Resume a pending completion |
| data_push_o | output | 1 | Stream one completion data beat |
| rem_bytes_o | output | BC_W | Remaining byte count |
| cur_addr_o | output | ADDR_W | Current address |
| msg_valid_o | output | 1 | Completion error message issued |
| msg_class_o | output | 4 | Message class |
| msg_index_o | output | 8 | Message index |
| tgt_abort_o | output | 1 | Signal target abort to initiator |
| disc_data_o | output | 1 | Signal disconnect with data to initiator |
| flush_o | output | 1 | Release the pending inbound queue entry |
| done_o | output | 1 | Terminal action pulse |
| done_code_o | output | 3 | Terminal status code |

## Verification
Every result of this block is registered. A beat, abort or termination sampled at one rising edge shows up on the outputs right after that same edge, and a pending-state entry or a resume shows up in the remaining-count behaviour at the following edge. The bench drives inputs on the falling edge. It advances its behavioural model at the rising edge and compares every output at the next falling edge, so each command, done pulse and count is checked in exactly the cycle it is due. The scenarios cover each abort kind in both modes, both abort-select settings, a park-and-resume sequence, a collision of an abort with the final beat, and long gaps between beats.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PEND   = 2'd2
  } state_t;

  typedef enum logic [2:0] {
    DC_NORMAL  = 3'd0,
    DC_MSG     = 3'd1,
    DC_TABORT  = 3'd2,
    DC_DISC    = 3'd3,
    DC_DISCARD = 3'd4
  } done_code_t;

  localparam logic [3:0] MSG_CLASS_ERR = 4'h2;
  localparam logic [7:0] IDX_MABORT    = 8'h80;
  localparam logic [7:0] IDX_TABORT    = 8'h81;

  typedef struct packed {
    logic       msg;
    logic [7:0] idx;
    logic       tabort;
    logic       disc;
    done_code_t code;
  } resp_t;

endpackage

// File: rtl/scr_abort_map.sv
module scr_abort_map
  import scr_pkg::*;
(
  input  logic  split_i,
  input  logic  ta_sel_i,
  input  logic  mabort_i,
  input  logic  tabort_i,
  output resp_t resp_o
);

  always_comb begin
    resp_o = '0;
    if (split_i) begin
      resp_o.msg  = 1'b1;
      resp_o.idx  = mabort_i ? IDX_MABORT : IDX_TABORT;
      resp_o.code = DC_MSG;
    end else if (tabort_i && !mabort_i && !ta_sel_i) begin
      resp_o.disc = 1'b1;
      resp_o.code = DC_DISC;
    end else begin
      resp_o.tabort = 1'b1;
      resp_o.code   = DC_TABORT;
    end
  end

endmodule

// File: rtl/scr_xfer_track.sv
module scr_xfer_track #(
  parameter int ADDR_W     = 32,
  parameter int BC_W       = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BC_W-1:0]   bytes_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BC_W-1:0]   rem_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [BC_W-1:0]   STEP_BC = BC_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] STEP_AD = ADDR_W'(BEAT_BYTES);

  logic [BC_W-1:0]   rem_n;
  logic [ADDR_W-1:0] addr_n;
  logic              en;

  always_comb begin
    en     = load_i | step_i;
    rem_n  = load_i ? bytes_i : (rem_o - STEP_BC);
    addr_n = load_i ? addr_i  : (addr_o + STEP_AD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_o  <= '0;
      addr_o <= '0;
    end else if (en) begin
      rem_o  <= rem_n;
      addr_o <= addr_n;
    end
  end

  assign last_o = (rem_o == STEP_BC);

endmodule

// File: rtl/scr_resp_top.sv
module scr_resp_top
  import scr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode_i,
  input  logic              ta_sel_i,
  input  logic              req_valid_i,
  input  logic [BC_W-1:0]   req_bytes_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              ib_beat_i,
  input  logic              ib_mabort_i,
  input  logic              ib_tabort_i,
  input  logic              bus_retry_i,
  input  logic              bus_bdisc_i,
  input  logic              bus_mabort_i,
  input  logic              bus_tabort_i,
  input  logic              resume_i,
  output logic              data_push_o,
  output logic [BC_W-1:0]   rem_bytes_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              msg_valid_o,
  output logic [3:0]        msg_class_o,
  output logic [7:0]        msg_index_o,
  output logic              tgt_abort_o,
  output logic              disc_data_o,
  output logic              flush_o,
  output logic              done_o,
  output logic [2:0]        done_code_o
);

  localparam int BEAT_BYTES = DATA_W / 8;

  state_t     state_q, state_n;
  resp_t      ab_resp;
  logic       load, step, last;
  logic       ib_abort, req_end, req_park;
  logic       push_n, msg_n, ta_n, disc_n, flush_n, done_n;
  logic [3:0] cls_n;
  logic [7:0] idx_n;
  done_code_t code_n;

  scr_abort_map u_map (
    .split_i  (split_mode_i),
    .ta_sel_i (ta_sel_i),
    .mabort_i (ib_mabort_i),
    .tabort_i (ib_tabort_i),
    .resp_o   (ab_resp)
  );

  scr_xfer_track #(
    .ADDR_W     (ADDR_W),
    .BC_W       (BC_W),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .bytes_i (req_bytes_i),
    .addr_i  (req_addr_i),
    .rem_o   (rem_bytes_o),
    .addr_o  (cur_addr_o),
    .last_o  (last)
  );

  assign ib_abort = ib_mabort_i | ib_tabort_i;
  assign req_end  = split_mode_i & (bus_mabort_i | bus_tabort_i);
  assign req_park = split_mode_i & (bus_retry_i | bus_bdisc_i);

  // Next-state and command decode; priority: internal abort, requester
  // abort, requester park, data beat.
  always_comb begin
    state_n = state_q;
    load    = 1'b0;
    step    = 1'b0;
    push_n  = 1'b0;
    msg_n   = 1'b0;
    cls_n   = '0;
    idx_n   = '0;
    ta_n    = 1'b0;
    disc_n  = 1'b0;
    flush_n = 1'b0;
    done_n  = 1'b0;
    code_n  = DC_NORMAL;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          load    = 1'b1;
          state_n = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (ib_abort) begin
          msg_n   = ab_resp.msg;
          cls_n   = ab_resp.msg ? MSG_CLASS_ERR : 4'h0;
          idx_n   = ab_resp.idx;
          ta_n    = ab_resp.tabort;
          disc_n  = ab_resp.disc;
          code_n  = ab_resp.code;
          flush_n = 1'b1;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (req_end) begin
          code_n  = DC_DISCARD;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (req_park) begin
          state_n = ST_PEND;
        end else if (ib_beat_i) begin
          step   = 1'b1;
          push_n = 1'b1;
          if (last) begin
            flush_n = 1'b1;
            done_n  = 1'b1;
            code_n  = DC_NORMAL;
            state_n = ST_IDLE;
          end
        end
      end
      ST_PEND: begin
        if (resume_i) state_n = ST_ACTIVE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      data_push_o <= 1'b0;
      msg_valid_o <= 1'b0;
      msg_class_o <= '0;
      msg_index_o <= '0;
      tgt_abort_o <= 1'b0;
      disc_data_o <= 1'b0;
      flush_o     <= 1'b0;
      done_o      <= 1'b0;
      done_code_o <= '0;
    end else begin
      state_q     <= state_n;
      data_push_o <= push_n;
      msg_valid_o <= msg_n;
      msg_class_o <= cls_n;
      msg_index_o <= idx_n;
      tgt_abort_o <= ta_n;
      disc_data_o <= disc_n;
      flush_o     <= flush_n;
      done_o      <= done_n;
      done_code_o <= code_n;
    end
  end

endmodule

// File: rtl/scr_resp_chk.sv
module scr_resp_chk
  import scr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_mode_i,
  input logic              ib_beat_i,
  input logic              ib_mabort_i,
  input logic              ib_tabort_i,
  input logic [1:0]        state_q,
  input logic              data_push_o,
  input logic [BC_W-1:0]   rem_bytes_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              msg_valid_o,
  input logic [3:0]        msg_class_o,
  input logic [7:0]        msg_index_o,
  input logic              tgt_abort_o,
  input logic              disc_data_o,
  input logic              flush_o,
  input logic              done_o,
  input logic [2:0]        done_code_o
);

  localparam int BEAT_BYTES = DATA_W / 8;

  a_r2_msg_fields: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (msg_class_o == 4'h2) &&
                    ((msg_index_o == 8'h80) || (msg_index_o == 8'h81)));

  a_r4_abort_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o || tgt_abort_o || disc_data_o) |-> (flush_o && done_o));

  a_r4_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_valid_o, tgt_abort_o, disc_data_o, data_push_o && !done_o}));

  a_r7_discard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_code_o == 3'd4) |->
      (!flush_o && !msg_valid_o && !tgt_abort_o && !disc_data_o));

  a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND) |=> ($stable(rem_bytes_o) && $stable(cur_addr_o)));

  a_r9_beat_counts: assert property (@(posedge clk) disable iff (!rst_n)
    data_push_o |-> (rem_bytes_o == $past(rem_bytes_o) - BC_W'(BEAT_BYTES)) &&
                    (cur_addr_o == $past(cur_addr_o) + ADDR_W'(BEAT_BYTES)));

  a_r11_conv_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode_i && state_q == ST_ACTIVE && !ib_beat_i &&
     !ib_mabort_i && !ib_tabort_i) |=> (state_q == ST_ACTIVE && !done_o));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind scr_resp_top scr_resp_chk #(
  .ADDR_W (ADDR_W),
  .BC_W   (BC_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .split_mode_i (split_mode_i),
  .ib_beat_i    (ib_beat_i),
  .ib_mabort_i  (ib_mabort_i),
  .ib_tabort_i  (ib_tabort_i),
  .state_q      (state_q),
  .data_push_o  (data_push_o),
  .rem_bytes_o  (rem_bytes_o),
  .cur_addr_o   (cur_addr_o),
  .msg_valid_o  (msg_valid_o),
  .msg_class_o  (msg_class_o),
  .msg_index_o  (msg_index_o),
  .tgt_abort_o  (tgt_abort_o),
  .disc_data_o  (disc_data_o),
  .flush_o      (flush_o),
  .done_o       (done_o),
  .done_code_o  (done_code_o)
);

// File: tb/scr_resp_top_tb.sv
module scr_resp_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int BC_W       = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              split_mode_i = 1'b1, ta_sel_i = 1'b1;
  logic              req_valid_i = 1'b0;
  logic [BC_W-1:0]   req_bytes_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              ib_beat_i = 1'b0, ib_mabort_i = 1'b0, ib_tabort_i = 1'b0;
  logic              bus_retry_i = 1'b0, bus_bdisc_i = 1'b0;
  logic              bus_mabort_i = 1'b0, bus_tabort_i = 1'b0, resume_i = 1'b0;
  logic              data_push_o, msg_valid_o, tgt_abort_o, disc_data_o;
  logic              flush_o, done_o;
  logic [BC_W-1:0]   rem_bytes_o;
  logic [ADDR_W-1:0] cur_addr_o;
  logic [3:0]        msg_class_o;
  logic [7:0]        msg_index_o;
  logic [2:0]        done_code_o;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model state
  int          m_state = 0;
  int          m_rem = 0;
  int unsigned m_addr = 0;
  int e_push, e_msg, e_cls, e_idx, e_ta, e_disc, e_flush, e_done, e_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_resp_top #(.ADDR_W(ADDR_W), .BC_W(BC_W), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .split_mode_i(split_mode_i), .ta_sel_i(ta_sel_i),
    .req_valid_i(req_valid_i), .req_bytes_i(req_bytes_i), .req_addr_i(req_addr_i),
    .ib_beat_i(ib_beat_i), .ib_mabort_i(ib_mabort_i), .ib_tabort_i(ib_tabort_i),
    .bus_retry_i(bus_retry_i), .bus_bdisc_i(bus_bdisc_i),
    .bus_mabort_i(bus_mabort_i), .bus_tabort_i(bus_tabort_i), .resume_i(resume_i),
    .data_push_o(data_push_o), .rem_bytes_o(rem_bytes_o), .cur_addr_o(cur_addr_o),
    .msg_valid_o(msg_valid_o), .msg_class_o(msg_class_o), .msg_index_o(msg_index_o),
    .tgt_abort_o(tgt_abort_o), .disc_data_o(disc_data_o), .flush_o(flush_o),
    .done_o(done_o), .done_code_o(done_code_o)
  );

  task automatic model_step();
    e_push = 0; e_msg = 0; e_cls = 0; e_idx = 0; e_ta = 0;
    e_disc = 0; e_flush = 0; e_done = 0; e_code = 0;
    if (!rst_n) begin
      m_state = 0; m_rem = 0; m_addr = 0;
    end else if (m_state == 0) begin
      if (req_valid_i) begin
        m_rem = int'(req_bytes_i); m_addr = req_addr_i; m_state = 1;
      end
    end else if (m_state == 1) begin
      if (ib_mabort_i || ib_tabort_i) begin
        e_flush = 1; e_done = 1; m_state = 0;
        if (split_mode_i) begin
          e_msg = 1; e_cls = 2; e_idx = ib_mabort_i ? 'h80 : 'h81; e_code = 1;
        end else if (ib_mabort_i || ta_sel_i) begin
          e_ta = 1; e_code = 2;
        end else begin
          e_disc = 1; e_code = 3;
        end
      end else if (split_mode_i && (bus_mabort_i || bus_tabort_i)) begin
        e_done = 1; e_code = 4; m_state = 0;
      end else if (split_mode_i && (bus_retry_i || bus_bdisc_i)) begin
        m_state = 2;
      end else if (ib_beat_i) begin
        e_push = 1; m_rem = m_rem - 4; m_addr = m_addr + 4;
        if (m_rem == 0) begin
          e_done = 1; e_flush = 1; e_code = 0; m_state = 0;
        end
      end
    end else begin
      if (resume_i) m_state = 1;
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "data_push", int'(data_push_o), e_push);
    chk(tag, "rem_bytes", int'(rem_bytes_o), m_rem);
    chk(tag, "cur_addr",  int'(cur_addr_o),  int'(m_addr));
    chk(tag, "msg_valid", int'(msg_valid_o), e_msg);
    chk(tag, "msg_class", int'(msg_class_o), e_cls);
    chk(tag, "msg_index", int'(msg_index_o), e_idx);
    chk(tag, "tgt_abort", int'(tgt_abort_o), e_ta);
    chk(tag, "disc_data", int'(disc_data_o), e_disc);
    chk(tag, "flush",     int'(flush_o),     e_flush);
    chk(tag, "done",      int'(done_o),      e_done);
    chk(tag, "done_code", int'(done_code_o), e_code);
  endtask

  // one clock: model advances at the rising edge, compare at the falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    req_valid_i = 0; ib_beat_i = 0; ib_mabort_i = 0; ib_tabort_i = 0;
    bus_retry_i = 0; bus_bdisc_i = 0; bus_mabort_i = 0; bus_tabort_i = 0;
    resume_i = 0;
  endtask

  task automatic start(string tag, int bytes, int unsigned addr);
    req_valid_i = 1; req_bytes_i = BC_W'(bytes); req_addr_i = addr;
    cyc(tag);
  endtask

  task automatic beats(string tag, int n);
    for (int i = 0; i < n; i++) begin
      ib_beat_i = 1;
      cyc(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc("R1"); cyc("R1");
    @(negedge clk); rst_n = 1;
    cyc("R1");

    // R9: split normal transfer with gaps, finishes on last beat
    split_mode_i = 1;
    start("R9", 16, 32'h1000);
    beats("R9", 2); cyc("R9"); cyc("R9"); beats("R9", 2);
    cyc("R12");

    // R8: retry, park, resume; then boundary disconnect, resume
    start("R8", 24, 32'h2000);
    beats("R8", 2);
    bus_retry_i = 1; ib_beat_i = 1; cyc("R8");
    ib_beat_i = 1; cyc("R8"); cyc("R8");
    resume_i = 1; cyc("R8");
    beats("R8", 1);
    bus_bdisc_i = 1; cyc("R8");
    resume_i = 1; cyc("R8");
    beats("R9", 3);

    // R2 / R4: split internal target abort
    start("R2", 32, 32'h3000);
    beats("R2", 1);
    ib_tabort_i = 1; cyc("R2");
    // R3: split internal master abort, then both together
    start("R3", 32, 32'h3100);
    ib_mabort_i = 1; cyc("R3");
    start("R3", 32, 32'h3200);
    ib_mabort_i = 1; ib_tabort_i = 1; cyc("R3");

    // R7: requester master abort and target abort discard
    start("R7", 16, 32'h4000);
    beats("R7", 1);
    bus_tabort_i = 1; ib_beat_i = 1; cyc("R7");
    start("R7", 16, 32'h4100);
    bus_mabort_i = 1; cyc("R7"); cyc("R7");

    // R10: abort together with the final beat, split then conventional
    start("R10", 8, 32'h5000);
    beats("R10", 1);
    ib_beat_i = 1; ib_tabort_i = 1; cyc("R10");

    split_mode_i = 0;
    // R5: conventional master abort
    start("R5", 16, 32'h6000);
    beats("R5", 1);
    ib_mabort_i = 1; cyc("R5");
    // R6: conventional target abort, both enable settings
    ta_sel_i = 1;
    start("R6", 16, 32'h6100);
    ib_tabort_i = 1; cyc("R6");
    ta_sel_i = 0;
    start("R6", 16, 32'h6200);
    beats("R6", 2);
    ib_tabort_i = 1; cyc("R6");
    start("R10", 4, 32'h6300);
    ib_beat_i = 1; ib_tabort_i = 1; cyc("R10");

    // R11: conventional waits and ignored retry / boundary disconnect / requester aborts
    start("R11", 12, 32'h7000);
    for (int i = 0; i < 6; i++) cyc("R11");
    bus_retry_i = 1; cyc("R11");
    bus_bdisc_i = 1; ib_beat_i = 1; cyc("R11");
    bus_mabort_i = 1; cyc("R11");
    beats("R11", 1); cyc("R11"); beats("R11", 1);
    cyc("R12"); cyc("R12");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule